// File: doc/BRIEF.md
# Pixel Port Timing Decoder

This block sits at the digital video input of an encoder. It takes 4:2:2 luma/chroma data in one of two layouts. The narrow layout carries all components as a multiplexed byte stream, one byte per clock. The wide layout carries luma on the low lane and alternating blue/red colour difference on the high lane, with one word every second clock. From either layout the block rebuilds co-sited luma/chroma sample sets and marks each one with a one-cycle valid strobe.

In slave operation the line and field timing comes from the stream itself. The block searches for the four-symbol marker (all ones, zero, zero, status word) and checks the status word's protection bits. If the check passes, it takes the field, vertical-blank and horizontal-blank flags from that word. A start-of-active marker also resets the component phase, so the first symbol after it is always blue difference. In master operation the flags come from free-running line and clock counters. Data is then taken only inside the counted active window, and any markers in the stream have no effect on the flags.

Line geometry (blanking length, active length, lines per frame and per first field, vertical-blank lines per field) is set by parameters. The defaults describe a 525-line system.

Top module: `vid_port_decoder`

## Requirements
- R1: While reset is high and in the first cycle after it, smp_valid is 0, h_flag is 1, v_flag is 1, f_flag is 0 and active_out is 0.
- R2: In narrow mode (wide_mode=0), the symbols after a start-of-active marker are taken one per clock in the order Cb, Y, Cr, Y. Two sample sets (Y0,Cb0,Cr0) and (Y1,Cb0,Cr0) are produced. The first set is valid in the cycle after the Cr symbol is captured, and the second in the cycle after it.
- R3: In wide mode (wide_mode=1), one word is captured every second clock, with Y on pix_lo and chroma on pix_hi (Cb in the first word of a pair, Cr in the second). Each pair of words yields two sample sets on consecutive cycles, both with that pair's Cb and Cr.
- R4: A marker is the symbols all-ones, zero, zero, XY on pix_lo. XY bit 6 is F, bit 5 is V and bit 4 is H (1 ends active video, 0 starts it). In slave mode, h_flag, v_flag and f_flag take these bits in the cycle after XY is captured.
- R5: XY must have bit 7 set and bits 3..0 equal to V^H, F^H, F^V and F^V^H. A status word that fails this check is ignored. The flags keep their values and no component realignment happens.
- R6: Every accepted start-of-active marker restarts the component phase, so its first following symbol is treated as Cb even when the previous line ended partway through a group.
- R7: No sample set is produced while H is 1, and no marker symbol is ever output as data.
- R8: active_out is 1 exactly when both h_flag and v_flag are 0.
- R9: In master mode (master_mode=1), with a line of 8+BLANK_CLKS+ACTIVE_CLKS clocks counted from reset, h_flag is 1 for the first 4+BLANK_CLKS clocks of each line. v_flag is 1 for the first VBLANK_LINES lines of each field. f_flag is 1 on the lines from FIELD1_LINES to the end of the frame.
- R10: In master mode, data is taken only in the last ACTIVE_CLKS clocks of each line, with the phase starting at Cb at the first of them. Markers in the stream do not affect the flags.
- R11: Data symbols from 01h to FEh pass to the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 0 = multiplexed byte lane, 1 = split luma/chroma lanes |
| master_mode | input | 1 | 0 = flags from embedded markers, 1 = flags from internal counters |
| pix_lo | input | DW | Multiplexed symbols (narrow) or luma and marker lane (wide) |
| pix_hi | input | DW | Chroma lane in wide mode |
| y_out | output | DW | Luma of the current sample set |
| cb_out | output | DW | Blue colour difference of the current sample set |
| cr_out | output | DW | Red colour difference of the current sample set |
| smp_valid | output | 1 | One-cycle strobe per sample set |
| h_flag | output | 1 | Horizontal blanking flag |
| v_flag | output | 1 | Vertical blanking flag |
| f_flag | output | 1 | Field flag |
| active_out | output | 1 | Inside the active picture |

## Verification
In master mode, two things can land in the same cycle: the counter-driven fall of the horizontal flag and the capture of a valid embedded status word that carries different field and vertical bits. The bench places such a marker so that its status word is captured on the same edge where the counter leaves horizontal blanking. It then checks the flag outputs cycle by cycle against values computed from the counter position alone. Any influence from the marker shows up as a field or vertical-blank mismatch at that cycle.

// File: rtl/vpd_pkg.sv
package vpd_pkg;

  // symbols per embedded timing marker
  localparam int MARK_LEN = 4;

  // timing flags, packed with f as the most significant bit
  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } vpd_flags_t;

  typedef enum logic [1:0] {
    SEEK,
    GOT_ONES,
    GOT_ZERO1,
    GOT_ZERO2
  } vpd_seek_e;

  // status word check: marker bit and four protection bits
  function automatic logic xy_valid(input logic [7:0] xy);
    logic f;
    logic v;
    logic h;
    f = xy[6];
    v = xy[5];
    h = xy[4];
    return xy[7] && (xy[3] == (v ^ h)) && (xy[2] == (f ^ h)) &&
           (xy[1] == (f ^ v)) && (xy[0] == (f ^ v ^ h));
  endfunction

endpackage

// File: rtl/vpd_code_detect.sv
module vpd_code_detect
  import vpd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic [DW-1:0] sym,
  output logic          in_code,
  output logic          sav_stb,
  output vpd_flags_t    flags
);

  localparam logic [DW-1:0] ALL_ONES = '1;
  localparam logic [DW-1:0] ALL_ZERO = '0;

  vpd_seek_e  st, st_nx;
  logic [7:0] xy;
  logic       at_xy;
  logic       good;

  assign xy      = sym[DW-1 -: 8];
  assign at_xy   = (st == GOT_ZERO2);
  assign good    = take && at_xy && xy_valid(xy);
  assign sav_stb = good && !xy[4];
  // symbol belongs to a marker: either a preamble is in progress or it starts one
  assign in_code = (st != SEEK) || (sym == ALL_ONES);

  always_comb begin
    st_nx = st;
    if (take) begin
      if (sym == ALL_ONES && !at_xy) begin
        st_nx = GOT_ONES;
      end else begin
        case (st)
          GOT_ONES:  st_nx = (sym == ALL_ZERO) ? GOT_ZERO1 : SEEK;
          GOT_ZERO1: st_nx = (sym == ALL_ZERO) ? GOT_ZERO2 : SEEK;
          default:   st_nx = SEEK;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SEEK;
      flags <= 3'b011;
    end else begin
      st <= st_nx;
      if (good) begin
        flags <= xy[6:4];
      end
    end
  end

endmodule

// File: rtl/vpd_master_timing.sv
module vpd_master_timing
  import vpd_pkg::*;
#(
  parameter int BLANK_CLKS   = 268,
  parameter int ACTIVE_CLKS  = 1440,
  parameter int FRAME_LINES  = 525,
  parameter int FIELD1_LINES = 263,
  parameter int VBLANK_LINES = 20
) (
  input  logic       clk,
  input  logic       rst,
  output vpd_flags_t flags,
  output logic       act,
  output logic       realign
);

  localparam int HBLK_END  = MARK_LEN + BLANK_CLKS;
  localparam int ACT_START = HBLK_END + MARK_LEN;
  localparam int LINE_CLKS = ACT_START + ACTIVE_CLKS;
  localparam int CW        = $clog2(LINE_CLKS);
  localparam int LW        = $clog2(FRAME_LINES);

  localparam logic [CW-1:0] H_LAST   = CW'(LINE_CLKS - 1);
  localparam logic [CW-1:0] H_BLKEND = CW'(HBLK_END);
  localparam logic [CW-1:0] H_ACT    = CW'(ACT_START);
  localparam logic [CW-1:0] H_PRE    = CW'(ACT_START - 1);
  localparam logic [LW-1:0] L_LAST   = LW'(FRAME_LINES - 1);
  localparam logic [LW-1:0] L_F2     = LW'(FIELD1_LINES);
  localparam logic [LW-1:0] L_VB     = LW'(VBLANK_LINES);

  logic [CW-1:0] hcnt;
  logic [LW-1:0] line;
  logic [LW-1:0] line_in_field;
  logic          second_field;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      line <= '0;
    end else if (hcnt == H_LAST) begin
      hcnt <= '0;
      line <= (line == L_LAST) ? '0 : line + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign second_field  = (line >= L_F2);
  assign line_in_field = second_field ? (line - L_F2) : line;

  assign flags.h = (hcnt < H_BLKEND);
  assign flags.v = (line_in_field < L_VB);
  assign flags.f = second_field;
  assign act     = (hcnt >= H_ACT);
  assign realign = (hcnt == H_PRE);

endmodule

// File: rtl/vpd_demux.sv
module vpd_demux #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wide,
  input  logic          accept,
  input  logic          realign,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] hi,
  output logic [DW-1:0] y_o,
  output logic [DW-1:0] cb_o,
  output logic [DW-1:0] cr_o,
  output logic          valid
);

  logic [1:0]    phase;
  logic          pending;
  logic [DW-1:0] y_h, y2_h, cb_h, cr_h;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      pending <= 1'b0;
      valid   <= 1'b0;
      y_o     <= '0;
      cb_o    <= '0;
      cr_o    <= '0;
      y_h     <= '0;
      y2_h    <= '0;
      cb_h    <= '0;
      cr_h    <= '0;
    end else begin
      valid <= 1'b0;
      if (realign) begin
        phase   <= '0;
        pending <= 1'b0;
      end else if (accept) begin
        if (!wide) begin
          case (phase)
            2'd0: cb_h <= lo;
            2'd1: y_h  <= lo;
            2'd2: begin
              y_o   <= y_h;
              cb_o  <= cb_h;
              cr_o  <= lo;
              cr_h  <= lo;
              valid <= 1'b1;
            end
            default: begin
              y_o   <= lo;
              cb_o  <= cb_h;
              cr_o  <= cr_h;
              valid <= 1'b1;
            end
          endcase
          phase <= phase + 2'd1;
        end else begin
          if (!phase[0]) begin
            cb_h <= hi;
            y_h  <= lo;
          end else begin
            y_o     <= y_h;
            cb_o    <= cb_h;
            cr_o    <= hi;
            cr_h    <= hi;
            y2_h    <= lo;
            valid   <= 1'b1;
            pending <= 1'b1;
          end
          phase <= {1'b0, ~phase[0]};
        end
      end else if (pending) begin
        // second luma of a wide-mode pair, on the idle clock
        y_o     <= y2_h;
        cb_o    <= cb_h;
        cr_o    <= cr_h;
        valid   <= 1'b1;
        pending <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vid_port_decoder.sv
module vid_port_decoder
  import vpd_pkg::*;
#(
  parameter int DW           = 8,
  parameter int BLANK_CLKS   = 268,
  parameter int ACTIVE_CLKS  = 1440,
  parameter int FRAME_LINES  = 525,
  parameter int FIELD1_LINES = 263,
  parameter int VBLANK_LINES = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wide_mode,
  input  logic          master_mode,
  input  logic [DW-1:0] pix_lo,
  input  logic [DW-1:0] pix_hi,
  output logic [DW-1:0] y_out,
  output logic [DW-1:0] cb_out,
  output logic [DW-1:0] cr_out,
  output logic          smp_valid,
  output logic          h_flag,
  output logic          v_flag,
  output logic          f_flag,
  output logic          active_out
);

  logic       tgl;
  logic       take;
  logic       in_code;
  logic       sav_stb;
  vpd_flags_t s_flags;
  vpd_flags_t m_flags;
  vpd_flags_t sel;
  logic       m_act;
  logic       m_realign;
  logic       accept;
  logic       realign;

  // wide mode captures one word on every second clock
  always_ff @(posedge clk) begin
    if (rst) tgl <= 1'b0;
    else     tgl <= ~tgl;
  end
  assign take = wide_mode ? tgl : 1'b1;

  vpd_code_detect #(.DW(DW)) det_i (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .sym     (pix_lo),
    .in_code (in_code),
    .sav_stb (sav_stb),
    .flags   (s_flags)
  );

  vpd_master_timing #(
    .BLANK_CLKS   (BLANK_CLKS),
    .ACTIVE_CLKS  (ACTIVE_CLKS),
    .FRAME_LINES  (FRAME_LINES),
    .FIELD1_LINES (FIELD1_LINES),
    .VBLANK_LINES (VBLANK_LINES)
  ) tim_i (
    .clk     (clk),
    .rst     (rst),
    .flags   (m_flags),
    .act     (m_act),
    .realign (m_realign)
  );

  assign accept  = master_mode ? (take && m_act) : (take && !in_code && !s_flags.h);
  assign realign = master_mode ? m_realign : sav_stb;

  vpd_demux #(.DW(DW)) dmx_i (
    .clk     (clk),
    .rst     (rst),
    .wide    (wide_mode),
    .accept  (accept),
    .realign (realign),
    .lo      (pix_lo),
    .hi      (pix_hi),
    .y_o     (y_out),
    .cb_o    (cb_out),
    .cr_o    (cr_out),
    .valid   (smp_valid)
  );

  assign sel        = master_mode ? m_flags : s_flags;
  assign h_flag     = sel.h;
  assign v_flag     = sel.v;
  assign f_flag     = sel.f;
  assign active_out = !sel.h && !sel.v;

endmodule

// File: rtl/vpd_chk.sv
module vpd_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          master_mode,
  input logic [DW-1:0] pix_lo,
  input logic          smp_valid,
  input logic          h_flag,
  input logic          v_flag,
  input logic          f_flag,
  input logic          active_out
);

  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst;

  always @(posedge clk) begin
    if (rst_seen === 1'b1) begin
      // R1
      reset_state_chk: assert (!smp_valid && h_flag && v_flag && !f_flag && !active_out);
    end
  end

  // R2
  burst_len_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && $past(smp_valid)) |=> !smp_valid);

  // R5
  flag_source_chk: assert property (@(posedge clk) disable iff (rst)
    (!master_mode && !$stable({f_flag, v_flag, h_flag})) |-> $past(pix_lo[DW-1]));

  // R7
  blank_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!master_mode && smp_valid) |-> !$past(h_flag));

  // R9
  field_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (master_mode && !$stable(f_flag)) |-> $rose(h_flag));

endmodule

bind vid_port_decoder vpd_chk #(.DW(DW)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .master_mode (master_mode),
  .pix_lo      (pix_lo),
  .smp_valid   (smp_valid),
  .h_flag      (h_flag),
  .v_flag      (v_flag),
  .f_flag      (f_flag),
  .active_out  (active_out)
);

// File: tb/vid_port_decoder_tb_top.sv
module vid_port_decoder_tb_top;

  localparam int DW  = 8;
  localparam int BLK = 12;
  localparam int ACT = 16;
  localparam int FL  = 6;
  localparam int F1  = 3;
  localparam int VB  = 1;
  localparam int LINE = 8 + BLK + ACT;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, wide_mode, master_mode;
  logic [DW-1:0] pix_lo, pix_hi, y_out, cb_out, cr_out;
  logic smp_valid, h_flag, v_flag, f_flag, active_out;

  int n_chk = 0;
  int n_bad = 0;
  int ncap = 0;
  logic [7:0] cy [64];
  logic [7:0] ccb[64];
  logic [7:0] ccr[64];

  vid_port_decoder #(
    .DW(DW), .BLANK_CLKS(BLK), .ACTIVE_CLKS(ACT),
    .FRAME_LINES(FL), .FIELD1_LINES(F1), .VBLANK_LINES(VB)
  ) dut_i (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .master_mode(master_mode),
    .pix_lo(pix_lo), .pix_hi(pix_hi), .y_out(y_out), .cb_out(cb_out),
    .cr_out(cr_out), .smp_valid(smp_valid), .h_flag(h_flag), .v_flag(v_flag),
    .f_flag(f_flag), .active_out(active_out)
  );

  always @(negedge clk) begin
    if (smp_valid && ncap < 64) begin
      cy[ncap]  = y_out;
      ccb[ncap] = cb_out;
      ccr[ncap] = cr_out;
      ncap++;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] xy(input bit f, input bit v, input bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic do_reset(input bit wide, input bit mst);
    rst = 1'b1;
    wide_mode = wide;
    master_mode = mst;
    pix_lo = 8'h10;
    pix_hi = 8'h80;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ncap = 0;
  endtask

  task automatic put8(input logic [7:0] b);
    @(negedge clk);
    pix_lo = b;
  endtask

  task automatic put16(input logic [7:0] lo, input logic [7:0] hi);
    @(negedge clk);
    pix_lo = lo;
    pix_hi = hi;
    @(negedge clk);
  endtask

  task automatic mark8(input logic [7:0] x);
    put8(8'hFF); put8(8'h00); put8(8'h00); put8(x);
  endtask

  task automatic mark16(input logic [7:0] x);
    put16(8'hFF, 8'h80); put16(8'h00, 8'h80); put16(8'h00, 8'h80); put16(x, 8'h80);
  endtask

  task automatic flags_are(input string req, input int h, input int v, input int f);
    check(req, "h_flag", h_flag, h);
    check(req, "v_flag", v_flag, v);
    check(req, "f_flag", f_flag, f);
    check("R8", "active_out", active_out, (h == 0 && v == 0) ? 1 : 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    wide_mode = 1'b0;
    master_mode = 1'b0;
    pix_lo = 8'h10;
    pix_hi = 8'h80;
    repeat (2) @(negedge clk);
    check("R1", "valid in reset", smp_valid, 0);
    flags_are("R1", 1, 1, 0);
    rst = 1'b0;
    ncap = 0;
    @(negedge clk);
    flags_are("R1", 1, 1, 0);
    for (int i = 0; i < 8; i++) put8(8'h55);
    put8(8'h10);
    check("R7", "samples before any marker", ncap, 0);
  endtask

  task automatic t_line8();
    logic [7:0] d[16] = '{8'h40, 8'h01, 8'hC0, 8'h51, 8'h41, 8'h52, 8'hFE, 8'h53,
                          8'h42, 8'h54, 8'hC2, 8'h55, 8'h43, 8'h56, 8'hC3, 8'h57};
    do_reset(1'b0, 1'b0);
    mark8(xy(0, 0, 1));
    put8(8'h10); put8(8'h80);
    flags_are("R4", 1, 0, 0);
    put8(8'h10); put8(8'h80);
    mark8(xy(0, 0, 0));
    for (int i = 0; i < 16; i++) begin
      put8(d[i]);
      if (i == 0) flags_are("R4", 0, 0, 0);
      if (i == 3) begin
        check("R2", "valid after Cr", smp_valid, 1);
        check("R2", "first luma", y_out, d[1]);
      end
      if (i == 4) begin
        check("R2", "valid second set", smp_valid, 1);
        check("R2", "second luma", y_out, d[3]);
      end
      if (i == 5) check("R2", "no valid after Cb", smp_valid, 0);
    end
    mark8(xy(0, 0, 1));
    put8(8'h10);
    flags_are("R4", 1, 0, 0);
    for (int i = 0; i < 6; i++) put8(8'h80);
    check("R7", "sample count narrow", ncap, 8);
    for (int j = 0; j < 8; j++) begin
      int p;
      p = j / 2;
      check("R2", "luma", cy[j], d[4*p + 1 + 2*(j%2)]);
      check("R2", "cb", ccb[j], d[4*p]);
      check("R2", "cr", ccr[j], d[4*p + 2]);
    end
    check("R11", "luma 01h", cy[0], 8'h01);
    check("R11", "cr FEh", ccr[2], 8'hFE);
  endtask

  task automatic t_protect();
    do_reset(1'b0, 1'b0);
    mark8(xy(0, 0, 1));
    put8(8'h10);
    flags_are("R4", 1, 0, 0);
    mark8(xy(1, 1, 1) ^ 8'h01);
    put8(8'h10);
    flags_are("R5", 1, 0, 0);
    mark8(xy(0, 1, 0) & 8'h7F);
    put8(8'h10);
    flags_are("R5", 1, 0, 0);
    mark8(xy(0, 0, 0) ^ 8'h02);
    put8(8'h40); put8(8'h60); put8(8'hC0); put8(8'h61); put8(8'h10);
    flags_are("R5", 1, 0, 0);
    check("R5", "no samples after bad start marker", ncap, 0);
    mark8(xy(0, 1, 0));
    put8(8'h10);
    flags_are("R4", 0, 1, 0);
    mark8(xy(1, 1, 1));
    put8(8'h10);
    flags_are("R4", 1, 1, 1);
  endtask

  task automatic t_realign();
    do_reset(1'b0, 1'b0);
    mark8(xy(0, 0, 1));
    put8(8'h10);
    mark8(xy(0, 0, 0));
    put8(8'h40); put8(8'h60); put8(8'hC0); put8(8'h61); put8(8'h41); put8(8'h62);
    mark8(xy(0, 0, 1));
    put8(8'h10); put8(8'h80);
    mark8(xy(0, 0, 0));
    put8(8'h48); put8(8'h70); put8(8'hC8); put8(8'h71);
    mark8(xy(0, 0, 1));
    put8(8'h10); put8(8'h10);
    check("R6", "sample count", ncap, 4);
    check("R6", "cb after realign", ccb[2], 8'h48);
    check("R6", "luma after realign", cy[2], 8'h70);
    check("R6", "cr after realign", ccr[2], 8'hC8);
    check("R6", "second luma after realign", cy[3], 8'h71);
  endtask

  task automatic t_wide();
    logic [7:0] yv[6] = '{8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26};
    logic [7:0] cv[6] = '{8'h40, 8'hC0, 8'h41, 8'hC1, 8'h42, 8'hC2};
    do_reset(1'b1, 1'b0);
    mark16(xy(0, 0, 1));
    put16(8'h10, 8'h80);
    flags_are("R3", 1, 0, 0);
    put16(8'h10, 8'h80); put16(8'h10, 8'h80);
    mark16(xy(0, 0, 0));
    for (int i = 0; i < 6; i++) begin
      put16(yv[i], cv[i]);
      if (i == 0) flags_are("R3", 0, 0, 0);
    end
    mark16(xy(0, 0, 1));
    put16(8'h10, 8'h80); put16(8'h10, 8'h80);
    check("R3", "sample count wide", ncap, 6);
    for (int j = 0; j < 6; j++) begin
      int p;
      p = j / 2;
      check("R3", "luma", cy[j], yv[j]);
      check("R3", "cb", ccb[j], cv[2*p]);
      check("R3", "cr", ccr[j], cv[2*p + 1]);
    end
  endtask

  task automatic t_master();
    do_reset(1'b0, 1'b1);
    for (int k = 0; k < LINE * (FL + 1); k++) begin
      int cnt, ln, lif, he, ve, fe;
      cnt = k % LINE;
      ln  = (k / LINE) % FL;
      fe  = (ln >= F1) ? 1 : 0;
      lif = fe ? ln - F1 : ln;
      ve  = (lif < VB) ? 1 : 0;
      he  = (cnt < 4 + BLK) ? 1 : 0;
      check("R9", "master h", h_flag, he);
      check("R9", "master v", v_flag, ve);
      check("R9", "master f", f_flag, fe);
      check("R8", "master active", active_out, (he == 0 && ve == 0) ? 1 : 0);
      // conflicting marker whose status word lands on the edge where h falls
      if (cnt < BLK) pix_lo = 8'h10;
      else if (cnt == BLK || cnt == BLK + 4) pix_lo = 8'hFF;
      else if (cnt == BLK + 3) pix_lo = xy(1, 1, 0);
      else if (cnt == BLK + 7) pix_lo = xy(0, 0, 0);
      else if (cnt < BLK + 8) pix_lo = 8'h00;
      else pix_lo = 8'(8'h30 + 16 * (ln % 4) + (cnt - 8 - BLK));
      @(negedge clk);
    end
    @(negedge clk);
    check("R10", "master sample count", ncap, 8 * (FL + 1));
    for (int j = 0; j < 8 * (FL + 1); j++) begin
      int ln, s, p, base;
      ln   = (j / 8) % FL;
      s    = j % 8;
      p    = s / 2;
      base = 8'h30 + 16 * (ln % 4);
      check("R10", "master luma", cy[j], base + 4*p + 1 + 2*(s%2));
      check("R10", "master cb", ccb[j], base + 4*p);
      check("R10", "master cr", ccr[j], base + 4*p + 2);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_line8();
    t_protect();
    t_realign();
    t_wide();
    t_master();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule